// File: doc/BRIEF.md
# Fixed-Priority Bus Arbiter with Grant Timeout

This block decides which of four bus masters may drive a shared parallel bus. Each master has a request line and a grant line, both active low. When the bus is idle and no grant is held, the arbiter hands the grant to the requesting master with the smallest index. The bus start and ready strobes, also active low, tell the arbiter when the granted master has begun a transaction and when the bus has returned to idle.

A grant that has not yet been used can be taken back. This happens in three cases: a master with a smaller index starts requesting, the holder drops its own request, or the holder lets sixteen clocks pass without starting a transaction. Once the holder has started, the grant stays until the start strobe deasserts. After a grant is removed there is always one clock with no grant before the next one is issued.

Top module: `pci_arb4`

## Requirements
- R1: At most one bit of `gnt_n` is low in any clock. During reset and just after it, `gnt_n` is 4'b1111.
- R2: Bit i of `req_n` and bit i of `gnt_n` belong to master i. Master 0 has the highest priority and master 3 the lowest. If no grant is held, `frame_n` and `irdy_n` are both high, and at least one request is low at a rising edge, then after that edge the grant goes to the lowest-indexed requester.
- R3: If no grant is held and `frame_n` or `irdy_n` is low at an edge, no grant is issued at that edge.
- R4: If a grant is held, the holder has not started, and a master with a smaller index is requesting at an edge, the grant is removed at that edge. A request from a master with a larger index has no effect on the grant.
- R5: If the holder's own request is high at an edge before it has started, the grant is removed. This includes the case where nothing is requesting.
- R6: A grant whose holder never drives `frame_n` low is asserted for exactly 16 clocks and is then removed. A grant issued later starts a fresh count of 16.
- R7: If `frame_n` is low at an edge while a grant is held, the holder has started. The grant then stays, whatever the requests are and however long it lasts, until `frame_n` is sampled high. It is removed at that edge.
- R8: A grant never changes directly from one master to another. At least one clock with `gnt_n` at 4'b1111 lies between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_n | input | 4 | Request per master, active low |
| frame_n | input | 1 | Transaction start strobe, active low |
| irdy_n | input | 1 | Initiator ready strobe, active low |
| gnt_n | output | 4 | Grant per master, active low |

## Verification
The checker assumes that `frame_n` goes low only when the grant holder drives it, or during a transaction that was already in progress before a grant was issued. It does not expect an idle bus to show a start strobe from an agent that holds no grant. The bench keeps to this. It drives `frame_n` low only after checking that a grant is present, and when it wants to model a busy bus with no grant, it does so with `irdy_n` alone. All inputs change just after a rising edge, so every request pattern reaches the arbiter as a clean, synchronous sample.

// File: rtl/pci_arb4.sv
module pci_arb4 #(
  parameter int NREQ    = 4,
  parameter int TIMEOUT = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] req_n,
  input  logic            frame_n,
  input  logic            irdy_n,
  output logic [NREQ-1:0] gnt_n
);
  localparam int IW = $clog2(NREQ);
  localparam int CW = $clog2(TIMEOUT);

  logic          gnt_vld, busy;
  logic [IW-1:0] owner, win;
  logic [CW-1:0] cnt;

  wire [NREQ-1:0] req     = ~req_n;
  wire [NREQ-1:0] own_oh  = NREQ'(1) << owner;
  wire [NREQ-1:0] hi_mask = own_oh - NREQ'(1);
  wire            idle    = frame_n & irdy_n;
  wire            expired = cnt == CW'(TIMEOUT - 1);
  wire            yank    = |(req & hi_mask) | ~req[owner] | expired;
  wire            drop    = frame_n & (busy | yank);

  always_comb begin
    win = '0;
    for (int i = NREQ - 1; i >= 0; i--)
      if (req[i]) win = IW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_vld <= 1'b0;
      busy    <= 1'b0;
      owner   <= '0;
      cnt     <= '0;
    end else if (gnt_vld) begin
      if (drop) begin
        gnt_vld <= 1'b0;
        busy    <= 1'b0;
      end else if (!frame_n) begin
        busy <= 1'b1;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end else if (|req && idle) begin
      gnt_vld <= 1'b1;
      owner   <= win;
      cnt     <= '0;
      busy    <= 1'b0;
    end
  end

  assign gnt_n = gnt_vld ? ~own_oh : '1;
endmodule

module pci_arb4_chk #(
  parameter int NREQ = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NREQ-1:0] req_n,
  input logic            frame_n,
  input logic            irdy_n,
  input logic [NREQ-1:0] gnt_n
);
  wire [NREQ-1:0] g      = ~gnt_n;
  wire [NREQ-1:0] r      = ~req_n;
  wire [NREQ-1:0] lowbit = r & (~r + NREQ'(1));

  // R1
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(g));

  // R2
  pick_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (g == '0 && frame_n && irdy_n && r != '0) |=> g == $past(lowbit));

  // R3
  busy_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (g == '0 && !(frame_n && irdy_n)) |=> g == '0);

  // R4
  preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (g != '0 && frame_n && (r & (g - NREQ'(1))) != '0) |=> g == '0);

  // R7
  hold_in_txn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (g != '0 && !frame_n) |=> g == $past(g));

  // R8
  gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (g != '0) |=> (g == '0 || g == $past(g)));
endmodule

bind pci_arb4 pci_arb4_chk #(.NREQ(NREQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_n(req_n),
  .frame_n(frame_n), .irdy_n(irdy_n), .gnt_n(gnt_n)
);

// File: tb/pci_arb4_bench.sv
module pci_arb4_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] req_n;
  logic       frame_n, irdy_n;
  logic [3:0] gnt_n;
  int vectors = 0;
  int miscmp  = 0;

  pci_arb4 u_pci_arb4 (
    .clk(clk), .rst_n(rst_n), .req_n(req_n),
    .frame_n(frame_n), .irdy_n(irdy_n), .gnt_n(gnt_n)
  );

  always #2 clk = ~clk;

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic [3:0] exp, input string tag);
    vectors++;
    if (gnt_n !== exp) begin
      miscmp++;
      $display("FAIL %s gnt_n=%b expected %b", tag, gnt_n, exp);
    end
  endtask

  function automatic logic [3:0] low_of(input logic [3:0] p);
    return p & (~p + 4'd1);
  endfunction

  initial begin
    #(4 * 200000);
    miscmp++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_n = 4'hF; frame_n = 1'b1; irdy_n = 1'b1;
    repeat (3) step();
    chk(4'hF, "R1 reset");
    rst_n = 1'b1;
    step();
    chk(4'hF, "R1 after reset");

    for (int p = 0; p < 16; p++) begin
      req_n = ~4'(p);
      step();
      chk(~low_of(4'(p)), "R2 sweep");
      req_n = 4'hF;
      step();
      chk(4'hF, "R5 release");
    end

    for (int m = 0; m < 4; m++) begin
      req_n = ~(4'd1 << m);
      step();
      for (int k = 1; k < 16; k++) begin
        step();
        chk(~(4'd1 << m), "R6 still held");
      end
      step();
      chk(4'hF, "R6 expiry");
      step();
      chk(~(4'd1 << m), "R6 regrant");
      for (int k = 1; k < 16; k++) step();
      chk(~(4'd1 << m), "R6 fresh count");
      req_n = 4'hF;
      step();
      chk(4'hF, "R5 drop own");
    end

    for (int j = 1; j < 4; j++) begin
      for (int i = 0; i < j; i++) begin
        req_n = ~(4'd1 << j);
        step(); step();
        chk(~(4'd1 << j), "R2 single");
        req_n = ~((4'd1 << j) | (4'd1 << i));
        step();
        chk(4'hF, "R4 preempt");
        step();
        chk(~(4'd1 << i), "R8 gap then higher");
        req_n = ~((4'd1 << j) | (4'd1 << i));
        step();
        chk(~(4'd1 << i), "R4 lower ignored");
        req_n = 4'hF;
        step(); step();
        chk(4'hF, "R5 idle");
      end
    end

    for (int m = 0; m < 4; m++) begin
      req_n = ~(4'd1 << m);
      step();
      chk(~(4'd1 << m), "R2 before txn");
      frame_n = 1'b0;
      req_n = ~((4'd1 << m) | 4'd1);
      step();
      for (int k = 0; k < 20; k++) begin
        req_n = (k % 2 == 0) ? 4'hF : 4'h0;
        step();
        chk(~(4'd1 << m), "R7 held in txn");
      end
      frame_n = 1'b1; irdy_n = 1'b0; req_n = ~((4'd1 << m) | 4'd1);
      step();
      chk(4'hF, "R7 release");
      step();
      chk(4'hF, "R3 bus busy");
      irdy_n = 1'b1;
      step();
      chk(4'hE, "R2 after txn");
      req_n = 4'hF;
      step(); step();
    end

    irdy_n = 1'b0; req_n = 4'h0;
    for (int k = 0; k < 4; k++) begin
      step();
      chk(4'hF, "R3 no grant while ready low");
    end
    irdy_n = 1'b1;
    step();
    chk(4'hE, "R1 R2 single grant");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end
endmodule